// File: doc/BRIEF.md
# PHY Event Interrupt Controller

This block gathers link-related event pulses from a transceiver's line logic into a 16-bit sticky status word. It qualifies that word through a per-event suppression register and drives one active-high interrupt line toward the host. A global suppression bit in a separate control word overrides every per-event setting. A force bit lets software raise the line without any event.

Software reaches the block through a simple management register port. The port has a 5-bit address, write and read strobes, and a 16-bit data bus in each direction. The sticky status word is acknowledged only by reading it: the read returns the captured events and empties the word in the same cycle. An event that lands in that same cycle is kept for the next read.

Top module: `phy_evt_irq_ctrl`

## Requirements
- R1: A one-cycle pulse on `evt_i[k]` sets status bit k on the next clock edge. The bit stays set until a status read, and further events OR into the word. The bit meanings are: 0 CRC error, 1 link change, 2 speed change, 3 duplex change, 4 local receiver change, 5 remote receiver change, 6 scrambler sync error, 7 unsupported HCD, 8 no HCD, 9 no HCD link, 10 autoneg page received, 11 counters low, 12 counter high, 13 MDIX change, 14 pair swap error. Bit 15 always reads 0, and the word is 0 after reset.
- R2: A read of address 0x1A returns the status word and clears it. Reads of other addresses leave it unchanged, and writes to 0x1A have no effect.
- R3: An event that arrives in the same cycle as a clearing read is not part of that read's data. It remains latched and is returned by the following read.
- R4: Address 0x1B is a read/write 16-bit mask. A 1 in bit k keeps status bit k from raising the interrupt. It resets to 0xFFFF.
- R5: Address 0x10 bit 12 is the global mask. While it is 1, `irq_o` is 0 whatever the status, mask and force bits hold. It resets to 1, and the register reads back with all other bits 0 apart from bit 11.
- R6: Address 0x10 bit 11 is the force bit. When it is 1 and the global mask is 0, `irq_o` is 1 even with no unmasked event. It resets to 0.
- R7: Address 0x11 bit 12 reads 1 exactly when an unmasked status bit is set or the force bit is set, independent of the global mask. All other bits of 0x11 read 0.
- R8: `irq_o` is a register. Its value is (OR of status AND NOT mask, OR force) AND NOT global mask, computed from the state of the previous cycle, so it follows a state change by one clock.
- R9: `mgmt_rdata` is registered. It holds the addressed word in the cycle after a read strobe, reads 0 for unmapped addresses, and is 0 in a cycle that follows no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 15 | Single-cycle event pulses, one per status bit |
| mgmt_addr | input | 5 | Management register address |
| mgmt_wr | input | 1 | Write strobe |
| mgmt_rd | input | 1 | Read strobe |
| mgmt_wdata | input | 16 | Write data |
| mgmt_rdata | output | 16 | Registered read data |
| irq_o | output | 1 | Registered active-high interrupt |

## Verification
The bench aims an event at the exact cycle of a clearing status read. A design that clears unconditionally would lose that event, and one that merges it into the read data would report it twice. The bench holds the global mask set while unmasked events and the force bit are present, which catches a gate applied only to the event path. It also writes to the status address and reads neighbouring registers, then reads the status word back. A design that treated such accesses as acknowledgements would show an empty word there. The bench also checks that the pending bit still reads 1 while the line is globally gated, which exposes a pending flag taken from the gated output.

// File: rtl/phy_irq_pkg.sv
package phy_irq_pkg;
  // management addresses
  localparam int unsigned ADDR_ECTL  = 5'h10;
  localparam int unsigned ADDR_ESTAT = 5'h11;
  localparam int unsigned ADDR_ISTAT = 5'h1A;
  localparam int unsigned ADDR_IMASK = 5'h1B;
  // field positions
  localparam int unsigned GMASK_BIT = 12;
  localparam int unsigned FORCE_BIT = 11;
  localparam int unsigned PEND_BIT  = 12;
endpackage

// File: rtl/evt_latch.sv
module evt_latch #(
  parameter int DW  = 16,
  parameter int EVW = 15
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [EVW-1:0] ev_i,
  input  logic           clr_i,
  output logic [DW-1:0]  stat_o
);
  localparam int PADW = DW - EVW;

  logic [DW-1:0] ev_ext;
  logic [DW-1:0] stat_q;

  assign ev_ext = {{PADW{1'b0}}, ev_i};

  always_ff @(posedge clk) begin
    if (rst)        stat_q <= '0;
    else if (clr_i) stat_q <= ev_ext;          // coincident events survive the clear
    else            stat_q <= stat_q | ev_ext;
  end

  assign stat_o = stat_q;

  // R1 / R3: every incoming event is present in the word one cycle later
  p_evt_kept_r3: assert property (@(posedge clk) disable iff (rst)
    (|ev_i) |=> ((stat_q[EVW-1:0] & $past(ev_i)) == $past(ev_i)));

  // R2: a clearing read with no new events empties the word
  p_clear_r2: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !(|ev_i)) |=> (stat_q == '0));

  // R2: without events or a clear the word holds
  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!clr_i && !(|ev_i)) |=> $stable(stat_q));

  // R1: the unused top bits never set
  p_top_zero_r1: assert property (@(posedge clk) disable iff (rst)
    stat_q[DW-1:EVW] == '0);
endmodule

// File: rtl/irq_gate.sv
module irq_gate #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] stat_i,
  input  logic [DW-1:0] mask_i,
  input  logic          force_i,
  input  logic          gmask_i,
  output logic          pend_o,
  output logic          irq_o
);
  logic irq_q;

  assign pend_o = (|(stat_i & ~mask_i)) | force_i;

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= pend_o & ~gmask_i;
  end

  assign irq_o = irq_q;

  // R5: global mask keeps the line low on the following cycle
  p_gmask_r5: assert property (@(posedge clk) disable iff (rst)
    gmask_i |=> !irq_o);

  // R6: force with the global mask clear raises the line
  p_force_r6: assert property (@(posedge clk) disable iff (rst)
    (force_i && !gmask_i) |=> irq_o);

  // R8: with nothing pending the line drops one cycle later
  p_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !pend_o |=> !irq_o);
endmodule

// File: rtl/mgmt_regs.sv
module mgmt_regs
  import phy_irq_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr_i,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] stat_i,
  input  logic          pend_i,
  output logic [DW-1:0] mask_o,
  output logic          gmask_o,
  output logic          force_o,
  output logic          clr_o,
  output logic [DW-1:0] rdata_o
);
  localparam logic [AW-1:0] A_ECTL  = AW'(ADDR_ECTL);
  localparam logic [AW-1:0] A_ESTAT = AW'(ADDR_ESTAT);
  localparam logic [AW-1:0] A_ISTAT = AW'(ADDR_ISTAT);
  localparam logic [AW-1:0] A_IMASK = AW'(ADDR_IMASK);

  logic [DW-1:0] mask_q;
  logic          gmask_q;
  logic          force_q;
  logic [DW-1:0] rdata_q;
  logic [DW-1:0] ctl_word;
  logic [DW-1:0] est_word;
  logic [DW-1:0] rd_mux;

  always_comb begin
    ctl_word            = '0;
    ctl_word[GMASK_BIT] = gmask_q;
    ctl_word[FORCE_BIT] = force_q;
    est_word            = '0;
    est_word[PEND_BIT]  = pend_i;
  end

  always_comb begin
    if      (addr_i == A_ECTL)  rd_mux = ctl_word;
    else if (addr_i == A_ESTAT) rd_mux = est_word;
    else if (addr_i == A_ISTAT) rd_mux = stat_i;
    else if (addr_i == A_IMASK) rd_mux = mask_q;
    else                        rd_mux = '0;
  end

  assign clr_o = rd_i && (addr_i == A_ISTAT);

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q  <= '1;
      gmask_q <= 1'b1;
      force_q <= 1'b0;
      rdata_q <= '0;
    end else begin
      if (wr_i && addr_i == A_ECTL) begin
        gmask_q <= wdata_i[GMASK_BIT];
        force_q <= wdata_i[FORCE_BIT];
      end
      if (wr_i && addr_i == A_IMASK) mask_q <= wdata_i;
      rdata_q <= rd_i ? rd_mux : '0;
    end
  end

  assign mask_o  = mask_q;
  assign gmask_o = gmask_q;
  assign force_o = force_q;
  assign rdata_o = rdata_q;

  // R9: read data is zero after a cycle with no read
  p_rdata_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !rd_i |=> (rdata_o == '0));

  // R4: a mask write is visible on the next cycle
  p_mask_wr_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_i && addr_i == A_IMASK) |=> (mask_o == $past(wdata_i)));
endmodule

// File: rtl/phy_evt_irq_ctrl.sv
module phy_evt_irq_ctrl #(
  parameter int DW  = 16,
  parameter int EVW = 15,
  parameter int AW  = 5
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [EVW-1:0] evt_i,
  input  logic [AW-1:0]  mgmt_addr,
  input  logic           mgmt_wr,
  input  logic           mgmt_rd,
  input  logic [DW-1:0]  mgmt_wdata,
  output logic [DW-1:0]  mgmt_rdata,
  output logic           irq_o
);
  logic [DW-1:0] stat;
  logic [DW-1:0] mask;
  logic          gmask;
  logic          frc;
  logic          clr;
  logic          pend;

  evt_latch #(.DW(DW), .EVW(EVW)) u_latch (
    .clk    (clk),
    .rst    (rst),
    .ev_i   (evt_i),
    .clr_i  (clr),
    .stat_o (stat)
  );

  mgmt_regs #(.DW(DW), .AW(AW)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .addr_i  (mgmt_addr),
    .wr_i    (mgmt_wr),
    .rd_i    (mgmt_rd),
    .wdata_i (mgmt_wdata),
    .stat_i  (stat),
    .pend_i  (pend),
    .mask_o  (mask),
    .gmask_o (gmask),
    .force_o (frc),
    .clr_o   (clr),
    .rdata_o (mgmt_rdata)
  );

  irq_gate #(.DW(DW)) u_gate (
    .clk     (clk),
    .rst     (rst),
    .stat_i  (stat),
    .mask_i  (mask),
    .force_i (frc),
    .gmask_i (gmask),
    .pend_o  (pend),
    .irq_o   (irq_o)
  );
endmodule

// File: tb/tb_phy_evt_irq_ctrl.sv
module tb_phy_evt_irq_ctrl;
  localparam logic [4:0] A_ECTL  = 5'h10;
  localparam logic [4:0] A_ESTAT = 5'h11;
  localparam logic [4:0] A_ISTAT = 5'h1A;
  localparam logic [4:0] A_IMASK = 5'h1B;
  localparam int NVEC = 8;
  // {mask[15:0], events[14:0], expected status[15:0], expected irq}
  localparam logic [47:0] VEC [0:NVEC-1] = '{
    {16'hFFF1, 15'h0002, 16'h0002, 1'b1},
    {16'hFFF1, 15'h0001, 16'h0001, 1'b0},
    {16'h0000, 15'h4000, 16'h4000, 1'b1},
    {16'hBFFF, 15'h2000, 16'h2000, 1'b0},
    {16'h0000, 15'h0000, 16'h0000, 1'b0},
    {16'h7FFF, 15'h7FFF, 16'h7FFF, 1'b0},
    {16'hFFFB, 15'h0404, 16'h0404, 1'b1},
    {16'h0000, 15'h7FFF, 16'h7FFF, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [14:0] evt_i = '0;
  logic [4:0]  mgmt_addr = '0;
  logic        mgmt_wr = 1'b0;
  logic        mgmt_rd = 1'b0;
  logic [15:0] mgmt_wdata = '0;
  logic [15:0] mgmt_rdata;
  logic        irq_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  phy_evt_irq_ctrl dut (
    .clk(clk), .rst(rst), .evt_i(evt_i), .mgmt_addr(mgmt_addr),
    .mgmt_wr(mgmt_wr), .mgmt_rd(mgmt_rd), .mgmt_wdata(mgmt_wdata),
    .mgmt_rdata(mgmt_rdata), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    mgmt_addr = a; mgmt_wdata = d; mgmt_wr = 1'b1;
    @(negedge clk);
    mgmt_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] d);
    @(negedge clk);
    mgmt_addr = a; mgmt_rd = 1'b1;
    @(negedge clk);
    mgmt_rd = 1'b0;
    d = mgmt_rdata;
  endtask

  task automatic pulse(input logic [14:0] e);
    @(negedge clk);
    evt_i = e;
    @(negedge clk);
    evt_i = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // reset state
    chk("R8 irq after reset", {15'h0, irq_o}, 16'h0);
    rd(A_ECTL, d);  chk("R5 ctrl reset", d, 16'h1000);
    rd(A_IMASK, d); chk("R4 mask reset", d, 16'hFFFF);
    rd(A_ISTAT, d); chk("R1 status reset", d, 16'h0000);
    rd(A_ESTAT, d); chk("R7 pending reset", d, 16'h0000);

    // vector table
    wr(A_ECTL, 16'h0000);
    for (int i = 0; i < NVEC; i++) begin
      wr(A_IMASK, VEC[i][47:32]);
      pulse(VEC[i][31:17]);
      @(negedge clk);
      chk("R8 irq from vector", {15'h0, irq_o}, {15'h0, VEC[i][0]});
      rd(A_ISTAT, d);
      chk("R1 status from vector", d, VEC[i][16:1]);
      @(negedge clk);
      chk("R2 irq drops after read", {15'h0, irq_o}, 16'h0);
    end

    // global mask overrides unmasked event
    wr(A_ECTL, 16'h1000);
    wr(A_IMASK, 16'h0000);
    pulse(15'h0004);
    repeat (2) @(negedge clk);
    chk("R5 global mask holds irq low", {15'h0, irq_o}, 16'h0);
    rd(A_ESTAT, d); chk("R7 pending while gated", d, 16'h1000);
    wr(A_ECTL, 16'h0000);
    @(negedge clk);
    chk("R5 irq after global unmask", {15'h0, irq_o}, 16'h1);
    rd(A_ISTAT, d); chk("R2 status read", d, 16'h0004);
    @(negedge clk);
    chk("R2 irq low after clear", {15'h0, irq_o}, 16'h0);

    // force
    wr(A_IMASK, 16'hFFFF);
    wr(A_ECTL, 16'h0800);
    @(negedge clk);
    chk("R6 force raises irq", {15'h0, irq_o}, 16'h1);
    rd(A_ESTAT, d); chk("R7 pending from force", d, 16'h1000);
    rd(A_ECTL, d);  chk("R9 ctrl readback", d, 16'h0800);
    wr(A_ECTL, 16'h1800);
    @(negedge clk);
    chk("R6 force gated by global mask", {15'h0, irq_o}, 16'h0);
    wr(A_ECTL, 16'h0000);
    @(negedge clk);
    chk("R6 force released", {15'h0, irq_o}, 16'h0);
    rd(A_ESTAT, d); chk("R7 no pending", d, 16'h0000);

    // event coincident with clearing read
    pulse(15'h0008);
    @(negedge clk);
    evt_i = 15'h0020; mgmt_addr = A_ISTAT; mgmt_rd = 1'b1;
    @(negedge clk);
    evt_i = '0; mgmt_rd = 1'b0;
    chk("R3 read excludes coincident event", mgmt_rdata, 16'h0008);
    rd(A_ISTAT, d); chk("R3 coincident event kept", d, 16'h0020);
    rd(A_ISTAT, d); chk("R2 cleared after read", d, 16'h0000);

    // writes and other reads leave status alone
    pulse(15'h0001);
    wr(A_ISTAT, 16'hFFFF);
    rd(A_IMASK, d); chk("R4 mask readback", d, 16'hFFFF);
    rd(A_ISTAT, d); chk("R2 write and other read ignored", d, 16'h0001);

    // accumulation
    pulse(15'h0200);
    pulse(15'h0400);
    rd(A_ISTAT, d); chk("R1 events accumulate", d, 16'h0600);

    // unmapped and idle read data
    rd(5'h05, d); chk("R9 unmapped reads zero", d, 16'h0000);
    rd(A_IMASK, d);
    @(negedge clk);
    chk("R9 rdata idle zero", mgmt_rdata, 16'h0000);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule